// File: doc/BRIEF.md
# Raster Line Timer with Vertical-Blank Interrupt

This block keeps the beam position of a tile-based video engine that runs three times faster than the CPU. The CPU side advances it one CPU cycle at a time. Each advance moves the horizontal position by three dots. The block folds dots into scanlines and scanlines into frames. It keeps the vertical-blank and sprite-zero-hit flags and drives an interrupt request line back to the CPU.

Software reaches the block through two actions. It writes a control byte whose top bit enables the interrupt, and it reads a status byte whose top two bits carry the blanking and hit flags. A status read clears the blanking flag. The CPU clears a pending interrupt with an acknowledge strobe, so one blanking period produces one interrupt. The renderer, which is outside this block, reports a sprite-zero hit through a strobe. A one-cycle pulse marks the end of every frame.

Top module: `raster_nmi_timer`

## Requirements
- R1: After synchronous reset, dot and scanline are 0, and the blanking flag, hit flag, interrupt request, frame pulse and status byte are all 0. The interrupt enable is off.
- R2: A cycle with `cpu_tick` high adds 3 to the dot position. A cycle with `cpu_tick` low leaves dot and scanline unchanged.
- R3: When the advanced dot value reaches 341 or more, dot becomes that value minus 341 and scanline increments. Dot stays below 341 and scanline stays below 262.
- R4: When scanline steps to 241, the blanking flag is set and the hit flag is cleared, whatever the interrupt enable holds.
- R5: When scanline steps to 241 with the interrupt enable (control bit 7) already set, `nmi_req` rises on the same edge.
- R6: A control write whose bit 7 is 1 while the stored enable is 0 and the blanking flag is 1 raises `nmi_req` at the next edge. A write that leaves the enable at 1, or any write while blanking is 0, raises nothing.
- R7: Once raised, `nmi_req` stays high across any number of cycles until an acknowledge or the frame wrap clears it.
- R8: `nmi_ack` clears `nmi_req` at the next edge, unless a new raise (R5 or R6) happens in the same cycle, in which case the raise wins.
- R9: `stat_rd` clears the blanking flag at the next edge; entry to line 241 in the same cycle wins. `status_byte` shows blanking in bit 7, hit in bit 6, and 0 in bits 5..0.
- R10: When scanline would reach 262 it returns to 0. Blanking, hit and `nmi_req` clear, and `frame_done` is high for exactly that one cycle.
- R11: `hit_set` sets the hit flag at the next edge. Entry to line 241 or the frame wrap in the same cycle wins and clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_tick | input | 1 | Advance by one CPU cycle (3 dots) |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data; bit 7 enables the interrupt |
| stat_rd | input | 1 | Status read strobe; clears blanking |
| nmi_ack | input | 1 | CPU acknowledge; clears the interrupt request |
| hit_set | input | 1 | Sprite-zero hit report from the renderer |
| nmi_req | output | 1 | Interrupt request to the CPU |
| vblank | output | 1 | Vertical-blank flag |
| spr0_hit | output | 1 | Sprite-zero-hit flag |
| status_byte | output | 8 | Bit 7 blanking, bit 6 hit, others 0 |
| scanline | output | 9 | Current scanline, 0..261 |
| dot | output | 9 | Current dot, 0..340 |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench runs about two full frames. It goes after the dot remainder at each line step: a design that reset dot to 0 would drift against the line count. It also targets the exact edge of blanking entry, where a design keyed on the wrong line or gated on the enable would set the flag early, late or not at all. It probes the late-enable path three ways: an enable rising during blanking, a redundant enable write, and an enable rise after a status read has cleared blanking. A design that did level detection or ignored blanking would then raise spurious interrupts, and one without the path would miss the late interrupt. Finally it checks that an interrupt, hit and blanking that are pending at the wrap all clear, together with a single-cycle frame pulse.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int DOTS_PER_LINE   = 341;
    localparam int LINES_PER_FRAME = 262;
    localparam int VBLANK_LINE     = 241;
    localparam int DOTS_PER_TICK   = 3;
    localparam int CTRL_W          = 8;
    localparam int NMI_EN_BIT      = 7;
    localparam int STAT_VBL_BIT    = 7;
    localparam int STAT_HIT_BIT    = 6;

    // Line events produced by the position counter for the current edge.
    typedef struct packed {
        logic enter_vblank;
        logic frame_wrap;
    } raster_evt_t;

    // Raise condition for a control write arriving while blanking is active.
    function automatic logic late_enable_rise(input logic old_en,
                                              input logic wr,
                                              input logic new_en,
                                              input logic in_vblank);
        return wr && new_en && !old_en && in_vblank;
    endfunction

endpackage

// File: rtl/raster_counter.sv
module raster_counter
    import raster_pkg::*;
#(
    parameter int DOTS  = DOTS_PER_LINE,
    parameter int LINES = LINES_PER_FRAME,
    parameter int VBL   = VBLANK_LINE,
    parameter int STEP  = DOTS_PER_TICK
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     tick,
    output logic [$clog2(DOTS)-1:0]  dot,
    output logic [$clog2(LINES)-1:0] line,
    output raster_evt_t              evt
);

    localparam int DOT_W  = $clog2(DOTS);
    localparam int LINE_W = $clog2(LINES);
    localparam int SUM_W  = DOT_W + 1;
    localparam int LW1    = LINE_W + 1;

    logic [SUM_W-1:0] dot_sum;
    logic [LW1-1:0]   line_inc;
    logic             line_step;

    always_comb begin
        dot_sum          = {1'b0, dot} + SUM_W'(STEP);
        line_inc         = {1'b0, line} + LW1'(1);
        line_step        = tick && (dot_sum >= SUM_W'(DOTS));
        evt.enter_vblank = line_step && (line_inc == LW1'(VBL));
        evt.frame_wrap   = line_step && (line_inc == LW1'(LINES));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dot  <= '0;
            line <= '0;
        end else if (tick) begin
            if (line_step) begin
                dot  <= DOT_W'(dot_sum - SUM_W'(DOTS));
                line <= evt.frame_wrap ? '0 : LINE_W'(line_inc);
            end else begin
                dot  <= DOT_W'(dot_sum);
            end
        end
    end

endmodule

// File: rtl/raster_ctrl_reg.sv
module raster_ctrl_reg
    import raster_pkg::*;
#(
    parameter int W      = CTRL_W,
    parameter int EN_BIT = NMI_EN_BIT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic         in_vblank,
    output logic         nmi_en,
    output logic         late_nmi
);

    localparam logic [W-1:0] EN_MASK = W'(1) << EN_BIT;

    logic         en_q;
    logic         unused_ctrl_bits;

    assign unused_ctrl_bits = ^(wdata & ~EN_MASK);
    assign nmi_en           = en_q;
    assign late_nmi         = late_enable_rise(en_q, we, wdata[EN_BIT], in_vblank);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
        end else if (we) begin
            en_q <= wdata[EN_BIT];
        end
    end

endmodule

// File: rtl/raster_flags.sv
module raster_flags
    import raster_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  raster_evt_t evt,
    input  logic        nmi_en,
    input  logic        late_nmi,
    input  logic        stat_rd,
    input  logic        nmi_ack,
    input  logic        hit_set,
    output logic        vblank,
    output logic        hit,
    output logic        nmi,
    output logic        frame_done
);

    // Later assignments take priority: strobes first, then line events.
    always_ff @(posedge clk) begin
        if (rst) begin
            vblank     <= 1'b0;
            hit        <= 1'b0;
            nmi        <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= evt.frame_wrap;
            if (hit_set)  hit    <= 1'b1;
            if (stat_rd)  vblank <= 1'b0;
            if (nmi_ack)  nmi    <= 1'b0;
            if (late_nmi) nmi    <= 1'b1;
            if (evt.enter_vblank) begin
                vblank <= 1'b1;
                hit    <= 1'b0;
                if (nmi_en) nmi <= 1'b1;
            end
            if (evt.frame_wrap) begin
                vblank <= 1'b0;
                hit    <= 1'b0;
                nmi    <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/raster_nmi_timer.sv
module raster_nmi_timer
    import raster_pkg::*;
#(
    parameter int DOTS    = DOTS_PER_LINE,
    parameter int LINES   = LINES_PER_FRAME,
    parameter int VBL     = VBLANK_LINE,
    parameter int STEP    = DOTS_PER_TICK,
    parameter int CW      = CTRL_W,
    parameter int EN_BIT  = NMI_EN_BIT,
    parameter int VBL_BIT = STAT_VBL_BIT,
    parameter int HIT_BIT = STAT_HIT_BIT
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cpu_tick,
    input  logic                     ctrl_we,
    input  logic [CW-1:0]            ctrl_wdata,
    input  logic                     stat_rd,
    input  logic                     nmi_ack,
    input  logic                     hit_set,
    output logic                     nmi_req,
    output logic                     vblank,
    output logic                     spr0_hit,
    output logic [CW-1:0]            status_byte,
    output logic [$clog2(LINES)-1:0] scanline,
    output logic [$clog2(DOTS)-1:0]  dot,
    output logic                     frame_done
);

    raster_evt_t evt;
    logic        nmi_en;
    logic        late_nmi;

    raster_counter #(
        .DOTS(DOTS), .LINES(LINES), .VBL(VBL), .STEP(STEP)
    ) u_counter (
        .clk  (clk),
        .rst  (rst),
        .tick (cpu_tick),
        .dot  (dot),
        .line (scanline),
        .evt  (evt)
    );

    raster_ctrl_reg #(
        .W(CW), .EN_BIT(EN_BIT)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .we        (ctrl_we),
        .wdata     (ctrl_wdata),
        .in_vblank (vblank),
        .nmi_en    (nmi_en),
        .late_nmi  (late_nmi)
    );

    raster_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .nmi_en     (nmi_en),
        .late_nmi   (late_nmi),
        .stat_rd    (stat_rd),
        .nmi_ack    (nmi_ack),
        .hit_set    (hit_set),
        .vblank     (vblank),
        .hit        (spr0_hit),
        .nmi        (nmi_req),
        .frame_done (frame_done)
    );

    always_comb begin
        status_byte          = '0;
        status_byte[VBL_BIT] = vblank;
        status_byte[HIT_BIT] = spr0_hit;
    end

endmodule

// File: rtl/raster_nmi_timer_chk.sv
module raster_nmi_timer_chk #(
    parameter int DOTS  = 341,
    parameter int LINES = 262,
    parameter int VBL   = 241,
    parameter int STEP  = 3
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     cpu_tick,
    input logic                     ctrl_we,
    input logic                     nmi_ack,
    input logic                     nmi_req,
    input logic                     vblank,
    input logic                     spr0_hit,
    input logic [$clog2(LINES)-1:0] scanline,
    input logic [$clog2(DOTS)-1:0]  dot,
    input logic                     frame_done
);

    localparam int DOT_W  = $clog2(DOTS);
    localparam int LINE_W = $clog2(LINES);

    // R2
    dot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cpu_tick |=> ($stable(dot) && $stable(scanline)));

    // R2
    dot_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_tick && int'(dot) < DOTS - STEP) |=> int'(dot) == int'($past(dot)) + STEP);

    // R3
    dot_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_tick && int'(dot) >= DOTS - STEP) |=> int'(dot) == int'($past(dot)) + STEP - DOTS);

    // R3
    pos_range_chk: assert property (@(posedge clk) disable iff (rst)
        (dot < DOT_W'(DOTS)) && (scanline < LINE_W'(LINES)));

    // R4
    vblank_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(vblank) |-> (scanline == LINE_W'(VBL)) && !spr0_hit);

    // R6
    nmi_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(nmi_req) |-> (vblank || $past(vblank)));

    // R8
    nmi_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (nmi_ack && !ctrl_we &&
         !(cpu_tick && scanline == LINE_W'(VBL - 1) && int'(dot) >= DOTS - STEP))
        |=> !nmi_req);

    // R10
    frame_clear_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (scanline == '0) && !vblank && !spr0_hit && !nmi_req);

    // R10
    frame_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

endmodule

bind raster_nmi_timer raster_nmi_timer_chk #(
    .DOTS(DOTS), .LINES(LINES), .VBL(VBL), .STEP(STEP)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_tick   (cpu_tick),
    .ctrl_we    (ctrl_we),
    .nmi_ack    (nmi_ack),
    .nmi_req    (nmi_req),
    .vblank     (vblank),
    .spr0_hit   (spr0_hit),
    .scanline   (scanline),
    .dot        (dot),
    .frame_done (frame_done)
);

// File: tb/raster_nmi_timer_bench.sv
`timescale 1ns/1ps
module raster_nmi_timer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_tick = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00;
    logic       stat_rd = 1'b0;
    logic       nmi_ack = 1'b0;
    logic       hit_set = 1'b0;
    logic       nmi_req, vblank, spr0_hit, frame_done;
    logic [7:0] status_byte;
    logic [8:0] scanline, dot;

    always #4 clk = ~clk;

    raster_nmi_timer u_raster_nmi_timer (
        .clk(clk), .rst(rst), .cpu_tick(cpu_tick), .ctrl_we(ctrl_we),
        .ctrl_wdata(ctrl_wdata), .stat_rd(stat_rd), .nmi_ack(nmi_ack),
        .hit_set(hit_set), .nmi_req(nmi_req), .vblank(vblank),
        .spr0_hit(spr0_hit), .status_byte(status_byte), .scanline(scanline),
        .dot(dot), .frame_done(frame_done)
    );

    typedef struct {
        string req;
        int    e_dot;
        int    e_line;
        bit    e_vbl;
        bit    e_hit;
        bit    e_nmi;
        bit    e_frame;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    // Reference state computed from the requirements
    int m_dot = 0, m_line = 0;
    bit m_vbl = 0, m_hit = 0, m_nmi = 0, m_frame = 0, m_en = 0;

    task automatic push_exp(input string req);
        exp_t e;
        e.req = req; e.e_dot = m_dot; e.e_line = m_line;
        e.e_vbl = m_vbl; e.e_hit = m_hit; e.e_nmi = m_nmi; e.e_frame = m_frame;
        q.push_back(e);
    endtask

    task automatic step(input bit tk, input bit we, input logic [7:0] wd,
                        input bit rd, input bit ak, input bit hs, input string req);
        bit rise, ent, wrap;
        @(negedge clk);
        cpu_tick = tk; ctrl_we = we; ctrl_wdata = wd;
        stat_rd = rd; nmi_ack = ak; hit_set = hs;
        @(posedge clk);
        #1;
        rise = we && wd[7] && !m_en && m_vbl;
        ent = 0; wrap = 0; m_frame = 0;
        if (tk) begin
            m_dot += 3;
            if (m_dot >= 341) begin
                m_dot -= 341;
                m_line++;
                if (m_line == 241) ent = 1;
                if (m_line == 262) begin m_line = 0; wrap = 1; end
            end
        end
        if (hs)   m_hit = 1;
        if (rd)   m_vbl = 0;
        if (ak)   m_nmi = 0;
        if (rise) m_nmi = 1;
        if (ent) begin m_vbl = 1; m_hit = 0; if (m_en) m_nmi = 1; end
        if (wrap) begin m_vbl = 0; m_hit = 0; m_nmi = 0; m_frame = 1; end
        if (we) m_en = wd[7];
        push_exp(req);
    endtask

    task automatic tick1(input string req);
        step(1, 0, 8'h00, 0, 0, 0, req);
    endtask

    task automatic ctrl_wr(input logic [7:0] v, input string req);
        step(0, 1, v, 0, 0, 0, req);
    endtask

    // Monitor: compares queued expectations against the outputs
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t e;
                logic [7:0] e_stat;
                e = q.pop_front();
                e_stat = {e.e_vbl, e.e_hit, 6'b0};
                n_checks++;
                if (int'(dot) != e.e_dot || int'(scanline) != e.e_line ||
                    vblank !== e.e_vbl || spr0_hit !== e.e_hit ||
                    nmi_req !== e.e_nmi || frame_done !== e.e_frame ||
                    status_byte !== e_stat) begin
                    n_fail++;
                    $display("FAIL %s: actual dot=%0d line=%0d vbl=%b hit=%b nmi=%b frame=%b stat=%h expected dot=%0d line=%0d vbl=%b hit=%b nmi=%b frame=%b stat=%h",
                             e.req, dot, scanline, vblank, spr0_hit, nmi_req, frame_done, status_byte,
                             e.e_dot, e.e_line, e.e_vbl, e.e_hit, e.e_nmi, e.e_frame, e_stat);
                end
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        push_exp("R1");                       // reset state

        tick1("R2");                          // dot 3
        step(0, 0, 8'h00, 0, 0, 0, "R2");     // idle hold
        tick1("R2");                          // dot 6
        ctrl_wr(8'h80, "R6");                 // enable outside blanking: no raise
        step(0, 0, 8'h00, 0, 0, 1, "R11");    // hit set, status 0x40

        while (m_line == 0) tick1("R3");      // first line step keeps remainder
        while (m_line < 240) tick1("R3");
        step(0, 0, 8'h00, 0, 0, 1, "R11");
        while (m_line == 240) tick1("R4 R5"); // blanking entry with enable set

        repeat (20) tick1("R7");              // request held
        step(0, 0, 8'h00, 0, 1, 0, "R8");     // ack clears
        repeat (5) tick1("R8");
        ctrl_wr(8'h00, "R6");
        ctrl_wr(8'h80, "R6");                 // late enable rise raises
        ctrl_wr(8'h80, "R6");                 // redundant write
        step(0, 0, 8'h00, 0, 0, 1, "R11");
        while (m_line != 0) tick1("R7 R10");  // held until wrap clears all
        tick1("R10");                          // pulse drops

        ctrl_wr(8'h00, "R4");                 // disable for second frame
        while (m_line < 241) tick1("R4");     // blanking sets, no request
        ctrl_wr(8'h80, "R6");                 // rise during blanking
        step(0, 0, 8'h00, 0, 1, 0, "R8");
        ctrl_wr(8'h80, "R6");                 // enable already 1: ignored
        step(0, 0, 8'h00, 1, 0, 0, "R9");     // read clears blanking
        ctrl_wr(8'h00, "R6");
        ctrl_wr(8'h80, "R6");                 // blanking clear: ignored
        repeat (10) tick1("R2");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule